// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a small up-counter whose every state change happens on the rising clock edge. An active-low clear sends the count to zero. An active-low load copies a parallel value into the count. Two active-high enables must both be high for the count to advance by one. The width is a parameter, and the default is 4 bits.

A carry output is high when the count is all ones and the second enable (`carry_in`) is high. The first enable (`cnt_en`) plays no part in it. Stages can therefore be chained by feeding each carry output into the next stage's `carry_in`, so that an upper stage advances only while every lower stage sits at all ones.

A modulo-N counter is made by decoding state N-1 onto the clear input. The counter then returns to zero on the edge after it reaches N-1.

Top module: `sync_bin_counter`

## Requirements
- R1: `count` changes only at a rising edge of `clk`. A change on any input between edges leaves `count` as it was.
- R2: With `clr_n` low at an edge, `count` becomes 0 whatever `load_n`, `cnt_en` and `carry_in` are.
- R3: With `clr_n` high and `load_n` low at an edge, `count` takes `load_val` whatever `cnt_en` and `carry_in` are.
- R4: With `clr_n` and `load_n` high and both `cnt_en` and `carry_in` high at an edge, `count` rises by one.
- R5: With `clr_n` and `load_n` high and either enable low at an edge, `count` keeps its value.
- R6: An increment from the all-ones value gives 0.
- R7: `carry_out` equals `carry_in` AND (`count` is all ones). It follows `carry_in` within the same cycle, and `cnt_en` has no effect on it.
- R8: Three 4-bit stages chained carry-to-`carry_in` form a 12-bit counter that steps through 0 to 4095 and wraps to 0.
- R9: Driving `clr_n` low on a decode of state 9 gives the repeating sequence 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable that does not gate the carry output |
| carry_in | input | 1 | Count enable that also gates the carry output |
| load_val | input | W | Value taken by a load |
| count | output | W | Current count |
| carry_out | output | 1 | High when `carry_in` is high and `count` is all ones |

## Verification
The hardest case to reach is the wrap of the top stage in a chain. That edge needs every lower stage at all ones at the same moment, which happens only once in 4096 cycles. The bench runs a three-stage chain through its full cycle and past the wrap, checking the 12-bit value on every cycle. A reference model, driven with random combinations of clear, load and enables, also covers the priority corners, such as clear together with load, and load with both enables low.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    // Operation chosen for the next edge, in priority order
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_INC   = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } sbc_op_e;
endpackage

// File: rtl/sbc_op_sel.sv
module sbc_op_sel
    import sbc_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    cnt_en,
    input  logic    carry_in,
    output sbc_op_e op
);
    always_comb begin
        if (!clr_n)                  op = OP_CLEAR;
        else if (!load_n)            op = OP_LOAD;
        else if (cnt_en && carry_in) op = OP_INC;
        else                         op = OP_HOLD;
    end
endmodule

// File: rtl/sbc_term_det.sv
module sbc_term_det #(
    parameter int W = 4
) (
    input  logic [W-1:0] count,
    input  logic         carry_in,
    output logic         carry_out
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_comb begin
        carry_out = carry_in && (count == ALL_ONES);
    end
endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
    import sbc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         cnt_en,
    input  logic         carry_in,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         carry_out
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] count;
    } state_t;

    state_t  state_d, state_q;
    sbc_op_e op;

    sbc_op_sel u_op_sel (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .carry_in (carry_in),
        .op       (op)
    );

    always_comb begin
        state_d = state_q;
        case (op)
            OP_CLEAR: state_d.count = '0;
            OP_LOAD:  state_d.count = load_val;
            OP_INC:   state_d.count = state_q.count + ONE;
            default:  state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count = state_q.count;

    sbc_term_det #(.W(W)) u_term_det (
        .count     (state_q.count),
        .carry_in  (carry_in),
        .carry_out (carry_out)
    );
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic         cnt_en,
    input logic         carry_in,
    input logic [W-1:0] load_val,
    input logic [W-1:0] count,
    input logic         carry_out
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Armed once a clear edge has defined the state
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) armed_q <= 1'b1;
    end

    // R2
    clear_wins_chk: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_n |=> count == '0);

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !load_n) |=> count == $past(load_val));

    // R4 R6
    step_up_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && load_n && cnt_en && carry_in) |=> count == $past(count) + ONE);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && load_n && !(cnt_en && carry_in)) |=> $stable(count));

    // R7
    carry_needs_max_chk: assert property (@(posedge clk) disable iff (!armed_q)
        carry_out |-> (carry_in && count == ALL_ONES));

    // R7
    carry_present_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (carry_in && count == ALL_ONES) |-> carry_out);
endmodule

bind sync_bin_counter sbc_chk #(.W(W)) u_chk (.*);

// File: tb/sync_bin_counter_tb.sv
module sync_bin_counter_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Main instance
    logic       clr_n = 1'b1, load_n = 1'b1, cnt_en = 1'b0, carry_in = 1'b0;
    logic [3:0] load_val = 4'd0;
    logic [3:0] count;
    logic       carry_out;

    sync_bin_counter #(.W(4)) u_dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_in(carry_in), .load_val(load_val), .count(count), .carry_out(carry_out)
    );

    // Three-stage chain
    logic       ch_clr_n = 1'b1;
    logic [3:0] c0, c1, c2;
    logic       t0, t1, t2;
    sync_bin_counter #(.W(4)) u_s0 (.clk(clk), .clr_n(ch_clr_n), .load_n(1'b1), .cnt_en(1'b1),
        .carry_in(1'b1), .load_val(4'd0), .count(c0), .carry_out(t0));
    sync_bin_counter #(.W(4)) u_s1 (.clk(clk), .clr_n(ch_clr_n), .load_n(1'b1), .cnt_en(1'b1),
        .carry_in(t0), .load_val(4'd0), .count(c1), .carry_out(t1));
    sync_bin_counter #(.W(4)) u_s2 (.clk(clk), .clr_n(ch_clr_n), .load_n(1'b1), .cnt_en(1'b1),
        .carry_in(t1), .load_val(4'd0), .count(c2), .carry_out(t2));

    // Modulo-10 instance
    logic       m_start_n = 1'b1;
    logic [3:0] mq;
    logic       mt;
    logic       m_clr_n;
    assign m_clr_n = m_start_n && (mq != 4'd9);
    sync_bin_counter #(.W(4)) u_m10 (.clk(clk), .clr_n(m_clr_n), .load_n(1'b1), .cnt_en(1'b1),
        .carry_in(1'b1), .load_val(4'd0), .count(mq), .carry_out(mt));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Inputs change at negedge; one rising edge passes; return at next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        clr_n = 1'b0; load_n = 1'b0; cnt_en = 1'b1; carry_in = 1'b1; load_val = 4'hA;
        step();
        check("R2 clear over load and enables", count, 0);
        clr_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0; carry_in = 1'b1;
        #1;
        check("R7 carry low at zero", carry_out, 0);
    endtask

    task automatic t_load_and_edge_only();
        load_n = 1'b0; load_val = 4'd6; cnt_en = 1'b0; carry_in = 1'b0;
        step();
        check("R3 load with enables low", count, 6);
        load_val = 4'd11; cnt_en = 1'b1; carry_in = 1'b1;
        #2;
        check("R1 no change between edges", count, 6);
        step();
        check("R3 load with enables high", count, 11);
        load_n = 1'b1; clr_n = 1'b0;
        #2;
        check("R1 clear waits for edge", count, 11);
        step();
        check("R2 clear at edge", count, 0);
        clr_n = 1'b1;
    endtask

    task automatic t_count_hold_wrap();
        load_n = 1'b0; load_val = 4'd13; step(); load_n = 1'b1;
        cnt_en = 1'b1; carry_in = 1'b1;
        step();
        check("R4 increment", count, 14);
        cnt_en = 1'b0; step();
        check("R5 hold when cnt_en low", count, 14);
        cnt_en = 1'b1; carry_in = 1'b0; step();
        check("R5 hold when carry_in low", count, 14);
        carry_in = 1'b1; step();
        check("R4 increment to max", count, 15);
        #1;
        check("R7 carry at max", carry_out, 1);
        cnt_en = 1'b0; #1;
        check("R7 cnt_en no effect on carry", carry_out, 1);
        carry_in = 1'b0; #1;
        check("R7 carry follows carry_in same cycle", carry_out, 0);
        cnt_en = 1'b1; carry_in = 1'b1; step();
        check("R6 wrap to zero", count, 0);
    endtask

    task automatic t_random_model();
        logic [3:0] exp_q = count;
        for (int i = 0; i < 400; i++) begin
            logic c, l, e, t;
            logic [3:0] v;
            c = ($urandom % 8) != 0; l = ($urandom % 4) != 0;
            e = ($urandom % 4) != 0; t = ($urandom % 4) != 0;
            v = 4'($urandom);
            clr_n = c; load_n = l; cnt_en = e; carry_in = t; load_val = v;
            #1;
            check("R7 random carry", carry_out, int'(t && exp_q == 4'hF));
            if (!c) exp_q = 4'd0;
            else if (!l) exp_q = v;
            else if (e && t) exp_q = exp_q + 4'd1;
            step();
            check("R4 R5 random model", count, exp_q);
        end
        clr_n = 1'b1; load_n = 1'b1;
    endtask

    task automatic t_cascade();
        ch_clr_n = 1'b0; step(); ch_clr_n = 1'b1;
        check("R8 chain cleared", {c2, c1, c0}, 0);
        for (int i = 1; i <= 4100; i++) begin
            step();
            check("R8 chain value", {c2, c1, c0}, i % 4096);
        end
    endtask

    task automatic t_mod10();
        m_start_n = 1'b0; step(); m_start_n = 1'b1;
        check("R9 mod10 start", mq, 0);
        for (int i = 1; i <= 25; i++) begin
            step();
            check("R9 mod10 sequence", mq, i % 10);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_load_and_edge_only();
        t_count_hold_wrap();
        t_random_model();
        t_cascade();
        t_mod10();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule